// File: doc/BRIEF.md
# Half-Band Two-Times Interpolator with Image Select and Midscale Stuffing

This block raises the rate of a 14-bit offset-binary sample stream by two using a symmetric half-band FIR. It runs from one fast clock. Three enable strobes mark the sample phases: `ce_1x` for input samples, `ce_2x` for filtered samples and `ce_4x` for output slots. In low-pass operation the interpolated stream keeps the baseband. In high-pass operation every second filtered sample is negated about midscale, which moves the response to the upper image and suppresses the baseband. A second mode bit adds one midscale sample after each filtered sample, which gives a 4x stream for direct-IF use.

The filter is split into two polyphase branches. The branch that feeds the even 2x slots is a pure delay: it outputs the stored sample `taps[HALF]`. The branch that feeds the odd 2x slots is a symmetric multiply-accumulate over the `2*HALF` stored inputs. Its result is kept at full precision, rounded half-up to 14 bits and clipped to the signed limits.

A three-state phase machine orders the slots:
- `PH_WAIT` is entered at reset. It moves to `PH_EVEN` when the first input is accepted.
- `PH_EVEN` moves to `PH_ODD` on `ce_2x`, after emitting the pure-delay sample.
- `PH_ODD` moves back to `PH_EVEN` on `ce_2x`, after emitting the interpolated sample. New inputs are shifted in on this same edge.

The environment must raise `ce_1x` together with every second `ce_2x`, and `ce_2x` together with every second `ce_4x`.

Top module: `halfband_interp2x`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `dout` is 14'h2000. Reset also fills the delay line with 14'h2000, so the pure-delay slots that follow a restart show midscale until new data reaches them.
- R2: The `ce_2x` edge that comes between two accepted inputs (in `PH_EVEN`) loads `dout` with the input accepted two 1x periods earlier. This slot is never negated in either filter mode.
- R3: With `mode[0]=0`, the `ce_2x` edge that accepts a new input (in `PH_ODD`) loads `dout` with the interpolated value. Take inputs a, b, c, d as the newest to oldest of the four stored samples, each converted to signed by subtracting 8192. The value is (-a + 9b + 9c - d + 8) >> 4, using an arithmetic shift, and 8192 is added back.
- R4: With `mode[0]=1`, that same interpolated slot carries the signed value negated before 8192 is added back. The pure-delay slot is unchanged.
- R5: With `mode[1]=1`, every `ce_4x` edge without `ce_2x` loads `dout` with midscale 14'h2000.
- R6: With `mode[1]=0`, every `ce_4x` edge without `ce_2x` leaves `dout` holding the last filtered sample.
- R7: The rounded interpolated value is clipped to the range -8192 to 8191, which is 14'h0000 to 14'h3FFF. When high-pass mode negates -8192, the result is 8191 (14'h3FFF).
- R8: `din` is captured only on a `ce_1x` edge in `PH_WAIT` or `PH_ODD`. Until the first capture, `dout` stays at midscale whatever the other strobes do. The first filtered slot is the next `ce_2x` edge after that capture.
- R9: `mode` is sampled on every slot. Bit 0 selects the filter response (0 = low-pass, 1 = high-pass) and bit 1 turns midscale stuffing on or off (1 = on). The two bits act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by all phases |
| rst | input | 1 | Synchronous reset, active high |
| ce_1x | input | 1 | Input-sample strobe |
| ce_2x | input | 1 | Filtered-sample strobe |
| ce_4x | input | 1 | Output-slot strobe |
| mode | input | 2 | Bit 0 high-pass select, bit 1 midscale-stuff enable |
| din | input | 14 | Offset-binary input sample |
| dout | output | 14 | Offset-binary output sample |

## Verification
The bench targets several corner cases, each with a distinct failure it would reveal:
- **Window order.** Sample sequences drive the accumulator past both clip limits. A design that wraps instead of clipping would show full-scale values of the wrong sign. One that pairs the coefficients with the wrong taps would give values that break the ordered-window formula.
- **High-pass at the negative limit.** The negation of the most negative value is checked. A naive two's-complement negate would give 14'h0000 where 14'h3FFF is due.
- **Slot alignment and polarity.** Every slot is compared in all four modes. A machine that starts in the wrong phase, or negates the pure-delay slot, would misplace or flip alternate samples.
- **Restarts and stray strobes.** Runs restart from reset while data fills the line, and idle strobes are sent without an input. These expose a delay line that is not cleared, and a machine that leaves its wait state without a capture.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    // Phase of the 2x filtered stream relative to accepted inputs
    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_EVEN = 2'd1,
        PH_ODD  = 2'd2
    } phase_e;

endpackage

// File: rtl/hbi_delay_line.sv
module hbi_delay_line #(
    parameter int DW  = 14,
    parameter int LEN = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift,
    input  logic [DW-1:0]           din,
    output logic [LEN-1:0][DW-1:0]  taps
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEN; i++) taps[i] <= MID;
        end else if (shift) begin
            taps[0] <= din;
            for (int i = 1; i < LEN; i++) taps[i] <= taps[i-1];
        end
    end
endmodule

// File: rtl/hbi_mac.sv
module hbi_mac #(
    parameter int DW    = 14,
    parameter int HALF  = 2,
    parameter int CW    = 16,
    parameter int CFRAC = 4,
    parameter logic signed [CW-1:0] COEF [HALF] = '{-16'sd1, 16'sd9}
) (
    input  logic [2*HALF-1:0][DW-1:0] taps,
    output logic [DW-1:0]             interp
);
    localparam int LEN = 2 * HALF;
    localparam int PW  = DW + 1;
    localparam int AW  = PW + CW + $clog2(HALF) + 1;
    localparam int RND = 1 << (CFRAC - 1);
    localparam logic [DW-1:0] MSK = DW'(1) << (DW - 1);
    localparam logic signed [AW-1:0] SMAX = AW'((1 << (DW - 1)) - 1);
    localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

    logic signed [AW-1:0] prod [HALF];
    logic signed [AW-1:0] acc, shr;
    logic signed [DW-1:0] res;

    // Symmetric pairs: coefficient k serves taps k and LEN-1-k
    for (genvar k = 0; k < HALF; k++) begin : g_pair
        logic signed [DW-1:0] sa, sb;
        logic signed [PW-1:0] ps;
        assign sa = signed'(taps[k] ^ MSK);
        assign sb = signed'(taps[LEN-1-k] ^ MSK);
        assign ps = PW'(sa) + PW'(sb);
        assign prod[k] = AW'(ps) * AW'(COEF[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < HALF; k++) acc = acc + prod[k];
        shr = (acc + AW'(RND)) >>> CFRAC;
        if (shr > SMAX)      res = SMAX[DW-1:0];
        else if (shr < SMIN) res = SMIN[DW-1:0];
        else                 res = shr[DW-1:0];
        interp = res ^ MSK;
    end
endmodule

// File: rtl/hbi_image_sel.sv
module hbi_image_sel #(
    parameter int DW = 14
) (
    input  logic [DW-1:0] v,
    input  logic          neg,
    output logic [DW-1:0] q
);
    localparam logic [DW-1:0] MSK  = DW'(1) << (DW - 1);
    localparam logic signed [DW-1:0] MINV = signed'(MSK);
    localparam logic signed [DW-1:0] MAXV = signed'(~MSK);

    logic signed [DW-1:0] s, r;

    always_comb begin
        s = signed'(v ^ MSK);
        if (neg) r = (s == MINV) ? MAXV : -s;
        else     r = s;
        q = r ^ MSK;
    end
endmodule

// File: rtl/halfband_interp2x.sv
module halfband_interp2x
    import hbi_pkg::*;
#(
    parameter int DW    = 14,
    parameter int HALF  = 2,
    parameter int CW    = 16,
    parameter int CFRAC = 4,
    parameter logic signed [CW-1:0] COEF [HALF] = '{-16'sd1, 16'sd9}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_1x,
    input  logic          ce_2x,
    input  logic          ce_4x,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int LEN = 2 * HALF;
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    phase_e st, st_nx;
    logic shift;
    logic [LEN-1:0][DW-1:0] taps;
    logic [DW-1:0] interp, img, filt, y2;

    // Phase register
    always_ff @(posedge clk) begin
        if (rst) st <= PH_WAIT;
        else     st <= st_nx;
    end

    // Phase transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            PH_WAIT: if (ce_1x) st_nx = PH_EVEN;
            PH_EVEN: if (ce_2x) st_nx = PH_ODD;
            PH_ODD:  if (ce_2x) st_nx = PH_EVEN;
            default: st_nx = PH_WAIT;
        endcase
    end

    assign shift = ce_1x && (st == PH_WAIT || st == PH_ODD);

    hbi_delay_line #(.DW(DW), .LEN(LEN)) u_line (
        .clk(clk), .rst(rst), .shift(shift), .din(din), .taps(taps)
    );

    hbi_mac #(.DW(DW), .HALF(HALF), .CW(CW), .CFRAC(CFRAC), .COEF(COEF)) u_mac (
        .taps(taps), .interp(interp)
    );

    hbi_image_sel #(.DW(DW)) u_img (
        .v(interp), .neg(mode[0]), .q(img)
    );

    // Pure-delay branch on even slots, filtered branch on odd slots
    assign filt = (st == PH_EVEN) ? taps[HALF] : img;

    // Output slots
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= MID;
            y2   <= MID;
        end else if (ce_2x) begin
            if (st == PH_WAIT) begin
                dout <= MID;
            end else begin
                dout <= filt;
                y2   <= filt;
            end
        end else if (ce_4x) begin
            dout <= mode[1] ? MID : y2;
        end
    end

    // R1 / R8: no sample leaves while waiting for the first input
    p_wait_mid_r8: assert property (@(posedge clk) disable iff (rst)
        (st == PH_WAIT) |-> (dout == MID));

    // R5: stuffed slots carry midscale
    p_stuff_mid_r5: assert property (@(posedge clk) disable iff (rst)
        (ce_4x && !ce_2x && mode[1]) |=> (dout == MID));

    // R6: without stuffing the filtered sample is held
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ce_4x && !ce_2x && !mode[1]) |=> $stable(dout));

    // R8: an input after the first arrives only on the odd 2x slot
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (ce_1x && st != PH_WAIT) |-> (st == PH_ODD && ce_2x));

    // R1: output moves only on a strobe
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!ce_2x && !ce_4x) |=> $stable(dout));
endmodule

// File: tb/halfband_interp2x_bench.sv
`timescale 1ns/1ps
module halfband_interp2x_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_1x = 1'b0, ce_2x = 1'b0, ce_4x = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [13:0] din = 14'h2000;
    logic [13:0] dout;

    always #4 clk = ~clk;

    halfband_interp2x u_halfband_interp2x (
        .clk(clk), .rst(rst), .ce_1x(ce_1x), .ce_2x(ce_2x), .ce_4x(ce_4x),
        .mode(mode), .din(din), .dout(dout)
    );

    localparam int NV = 16;
    localparam logic [13:0] VEC [NV] = '{
        14'h3FFF, 14'h3FFF, 14'h0000, 14'h0000, 14'h3FFF, 14'h3FFF, 14'h0000, 14'h0000,
        14'h2000, 14'h2100, 14'h2300, 14'h1F00, 14'h1A00, 14'h3FFF, 14'h0001, 14'h2777
    };

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    function automatic int xin(int i);
        if (i < 0 || i >= NV) return 8192;
        return int'(VEC[i]);
    endfunction

    task automatic chk(string tag, logic [13:0] got, int exp);
        n_chk++;
        if (got !== 14'(exp)) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, 14'(exp));
        end
    endtask

    task automatic run_mode(logic [1:0] md);
        int prev;
        ce_1x = 0; ce_2x = 0; ce_4x = 0; mode = md; rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 reset output", dout, 8192);
        rst = 0;
        prev = 8192;
        for (int k = 0; k < 4 * NV; k++) begin
            int expv, a, b, c, d, acc, r;
            string tag;
            ce_1x = (k % 4 == 0);
            ce_2x = (k % 2 == 0);
            ce_4x = 1'b1;
            din = (k % 4 == 0) ? 14'(xin(k / 4)) : 14'h1555;
            @(posedge clk); #1;
            if (k == 0) begin
                expv = 8192; tag = "R8 first capture slot";
            end else if (k % 4 == 2) begin
                expv = xin((k - 2) / 4 - 2); tag = "R2 pure-delay slot (R1 cleared line)";
                prev = expv;
            end else if (k % 4 == 0) begin
                a = xin(k / 4 - 1) - 8192; b = xin(k / 4 - 2) - 8192;
                c = xin(k / 4 - 3) - 8192; d = xin(k / 4 - 4) - 8192;
                acc = -a + 9 * b + 9 * c - d;
                r = (acc + 8) >>> 4;
                tag = md[0] ? "R4 high-pass slot" : "R3 low-pass slot";
                if (r > 8191) begin r = 8191; tag = "R7 clip high"; end
                if (r < -8192) begin r = -8192; tag = "R7 clip low"; end
                if (md[0]) r = (r == -8192) ? 8191 : -r;
                expv = r + 8192;
                prev = expv;
            end else begin
                expv = md[1] ? 8192 : prev;
                tag = md[1] ? "R5 stuffed slot" : "R6 held slot";
            end
            chk($sformatf("%s mode=%0d k=%0d (R9)", tag, md, k), dout, expv);
            @(negedge clk);
        end
        ce_1x = 0; ce_2x = 0; ce_4x = 0;
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 4; m++) run_mode(2'(m));

        // R8: strobes without an input keep the block waiting at midscale
        mode = 2'b10; rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int k = 0; k < 8; k++) begin
            ce_1x = 0; ce_2x = (k % 2 == 0); ce_4x = 1; din = 14'h3ABC;
            @(posedge clk); #1;
            chk("R8 no capture yet", dout, 8192);
            @(negedge clk);
        end
        ce_2x = 0; ce_4x = 0;

        // R1: reset in the middle of a stream clears output
        rst = 1;
        @(posedge clk); #1;
        chk("R1 mid-stream reset", dout, 8192);
        @(negedge clk);
        rst = 0;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule